// File: doc/BRIEF.md
# Eight-Channel Shared-Period PWM Timer

This block produces eight edge-aligned pulse-width-modulated outputs from a single 16-bit up-counter. One counting source, one power-of-two prescaler and one period limit are common to all outputs, so every channel runs at the same frequency. Each channel has its own compare threshold, polarity, per-channel gating and a fallback level that it drives whenever it is not actively producing a waveform.

Software programs the block over a simple word-addressed 32-bit write/read port. The word offsets are: 0x00 control, 0x04 period limit, 0x08 counter start value, 0x0C live counter, 0x10 polarity, 0x14 fallback levels, 0x18 output gate mask, and 0x20 + 4·n for channel n's compare value. In the control word, bits [2:0] hold the prescale exponent, bits [4:3] hold the counting-source code, and bit 16+n is channel n's enable. Bit n of the polarity, fallback and mask words belongs to channel n. The slower counting sources arrive as one-cycle enable pulses that are already synchronous to the block clock.

Top module: `pwm_shared_timer`

## Requirements
- R1: Every register reads back the last value written, with unused bits reading 0: control keeps bits [4:0] and [23:16] only, the period, start and compare registers keep bits [15:0], and the polarity, fallback and mask registers keep bits [7:0]. Offset 0x0C returns the live counter. Unmapped offsets read 0.
- R2: After reset the mask register reads 0xFF and all other registers and the counter read 0, so every output sits at fallback level 0.
- R3: The source code in control bits [4:3] selects the counting source: 0 stops counting and the counter holds its value, 1 counts on every clock, 2 counts on each `fix_tick` pulse, and 3 counts on each `ext_tick` pulse.
- R4: With prescale exponent P, the counter advances once every 2^P source pulses (P = 0 to 7).
- R5: When the counter advances from a value equal to the period limit, it goes back to the start value. Otherwise it increments by one modulo 2^16.
- R6: An active channel's raw waveform is high while counter < compare and low otherwise. A compare of 0 gives a constant low, and a compare above the period limit gives a constant high.
- R7: A set polarity bit inverts that channel's active waveform.
- R8: A set mask bit makes that channel drive its fallback bit instead of its waveform.
- R9: A cleared enable bit (control bit 16+n) makes channel n drive its fallback bit, even when the channel is unmasked.
- R10: A write to offset 0x0C, whatever its data, reloads the counter with the start value and restarts the prescaler phase. In that cycle the reload overrides any advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the system counting source |
| rst | input | 1 | Synchronous active-high reset |
| fix_tick | input | 1 | Enable pulse of the fixed-rate counting source |
| ext_tick | input | 1 | Enable pulse of the external counting source |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 8 | Channel outputs |

## Verification
The hardest situations to reach are the largest prescale setting combined with a short period, and a counter reload that arrives partway through a prescale phase. In both, the divider phase and the counter must stay in step over hundreds of cycles. The stimulus runs exponent 7 with a three-count period for long enough to see several wraps. It also writes the live counter offset at an arbitrary point inside a divide-by-8 phase. A per-cycle behavioural model tracks the counter and divider phase from the written values and irregular source pulses, and it compares all eight outputs on every clock.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int NUM_CH  = 8;
    localparam int CNT_W   = 16;
    localparam int PS_W    = 3;
    localparam int DW      = 32;
    localparam int AW      = 8;
    localparam int WIX_W   = AW - 2;
    localparam int DIV_W   = (1 << PS_W) - 1;
    localparam int EN_LSB  = 16;

    localparam logic [WIX_W-1:0] W_CTRL  = WIX_W'(0);
    localparam logic [WIX_W-1:0] W_MOD   = WIX_W'(1);
    localparam logic [WIX_W-1:0] W_START = WIX_W'(2);
    localparam logic [WIX_W-1:0] W_COUNT = WIX_W'(3);
    localparam logic [WIX_W-1:0] W_POL   = WIX_W'(4);
    localparam logic [WIX_W-1:0] W_OINIT = WIX_W'(5);
    localparam logic [WIX_W-1:0] W_MASK  = WIX_W'(6);
    localparam int               W_CMP0  = 8;

    typedef enum logic [1:0] {
        SRC_OFF = 2'd0,
        SRC_SYS = 2'd1,
        SRC_FIX = 2'd2,
        SRC_EXT = 2'd3
    } clk_src_e;

    typedef struct packed {
        logic [NUM_CH-1:0] ch_en;
        clk_src_e          src;
        logic [PS_W-1:0]   ps;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [DW-1:0] w);
        ctrl_t c;
        c.ps    = w[PS_W-1:0];
        c.src   = clk_src_e'(w[PS_W +: 2]);
        c.ch_en = w[EN_LSB +: NUM_CH];
        return c;
    endfunction

    function automatic logic [DW-1:0] ctrl_to_word(input ctrl_t c);
        logic [DW-1:0] w;
        w                  = '0;
        w[PS_W-1:0]        = c.ps;
        w[PS_W +: 2]       = c.src;
        w[EN_LSB +: NUM_CH] = c.ch_en;
        return w;
    endfunction

    function automatic logic [DIV_W-1:0] div_limit(input logic [PS_W-1:0] ps);
        return (DIV_W'(1) << ps) - DIV_W'(1);
    endfunction

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_timer_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_we,
    input  logic [AW-1:0]                 bus_addr,
    input  logic [DW-1:0]                 bus_wdata,
    input  logic [CNT_W-1:0]              count,
    output ctrl_t                         ctrl,
    output logic [CNT_W-1:0]              modulo,
    output logic [CNT_W-1:0]              start_val,
    output logic [NUM_CH-1:0]             pol,
    output logic [NUM_CH-1:0]             oinit,
    output logic [NUM_CH-1:0]             mask,
    output logic [NUM_CH-1:0][CNT_W-1:0]  cmp,
    output logic                          cnt_load,
    output logic [DW-1:0]                 bus_rdata
);

    logic [WIX_W-1:0] wix;
    assign wix      = bus_addr[AW-1:2];
    assign cnt_load = bus_we && (wix == W_COUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            modulo    <= '0;
            start_val <= '0;
            pol       <= '0;
            oinit     <= '0;
            mask      <= '1;
            cmp       <= '0;
        end else if (bus_we) begin
            unique case (wix)
                W_CTRL:  ctrl      <= ctrl_from_word(bus_wdata);
                W_MOD:   modulo    <= bus_wdata[CNT_W-1:0];
                W_START: start_val <= bus_wdata[CNT_W-1:0];
                W_POL:   pol       <= bus_wdata[NUM_CH-1:0];
                W_OINIT: oinit     <= bus_wdata[NUM_CH-1:0];
                W_MASK:  mask      <= bus_wdata[NUM_CH-1:0];
                default: begin
                    for (int n = 0; n < NUM_CH; n++) begin
                        if (wix == WIX_W'(W_CMP0 + n))
                            cmp[n] <= bus_wdata[CNT_W-1:0];
                    end
                end
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (wix)
            W_CTRL:  bus_rdata = ctrl_to_word(ctrl);
            W_MOD:   bus_rdata = DW'(modulo);
            W_START: bus_rdata = DW'(start_val);
            W_COUNT: bus_rdata = DW'(count);
            W_POL:   bus_rdata = DW'(pol);
            W_OINIT: bus_rdata = DW'(oinit);
            W_MASK:  bus_rdata = DW'(mask);
            default: begin
                for (int n = 0; n < NUM_CH; n++) begin
                    if (wix == WIX_W'(W_CMP0 + n))
                        bus_rdata = DW'(cmp[n]);
                end
            end
        endcase
    end

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_timer_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  clk_src_e        src,
    input  logic [PS_W-1:0] ps,
    input  logic            fix_tick,
    input  logic            ext_tick,
    input  logic            restart,
    output logic            tick,
    output logic            step
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim;
    logic             at_lim;

    assign lim    = div_limit(ps);
    assign at_lim = (div_q >= lim);

    always_comb begin
        unique case (src)
            SRC_OFF: tick = 1'b0;
            SRC_SYS: tick = 1'b1;
            SRC_FIX: tick = fix_tick;
            SRC_EXT: tick = ext_tick;
            default: tick = 1'b0;
        endcase
    end

    assign step = tick && at_lim;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            div_q <= '0;
        end else if (tick) begin
            if (at_lim) div_q <= '0;
            else        div_q <= div_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             load,
    input  logic [CNT_W-1:0] modulo,
    input  logic [CNT_W-1:0] start_val,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= start_val;
        end else if (step) begin
            if (cnt == modulo) cnt <= start_val;
            else               cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_timer_pkg::*;
(
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             pol,
    input  logic             masked,
    input  logic             enabled,
    input  logic             idle_lvl,
    output logic             out
);

    logic raw;
    logic active;

    assign raw    = (cnt < cmp);
    assign active = enabled && !masked;
    assign out    = active ? (raw ^ pol) : idle_lvl;

endmodule

// File: rtl/pwm_shared_timer.sv
module pwm_shared_timer
    import pwm_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fix_tick,
    input  logic              ext_tick,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    ctrl_t                        ctrl;
    logic [CNT_W-1:0]             modulo;
    logic [CNT_W-1:0]             start_val;
    logic [NUM_CH-1:0]            pol;
    logic [NUM_CH-1:0]            oinit;
    logic [NUM_CH-1:0]            mask;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp;
    logic                         cnt_load;
    logic                         tick;
    logic                         step;
    logic [CNT_W-1:0]             cnt;

    pwm_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .count     (cnt),
        .ctrl      (ctrl),
        .modulo    (modulo),
        .start_val (start_val),
        .pol       (pol),
        .oinit     (oinit),
        .mask      (mask),
        .cmp       (cmp),
        .cnt_load  (cnt_load),
        .bus_rdata (bus_rdata)
    );

    pwm_prescaler u_presc (
        .clk      (clk),
        .rst      (rst),
        .src      (ctrl.src),
        .ps       (ctrl.ps),
        .fix_tick (fix_tick),
        .ext_tick (ext_tick),
        .restart  (cnt_load),
        .tick     (tick),
        .step     (step)
    );

    pwm_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .load      (cnt_load),
        .modulo    (modulo),
        .start_val (start_val),
        .cnt       (cnt)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        pwm_channel u_ch (
            .cnt      (cnt),
            .cmp      (cmp[n]),
            .pol      (pol[n]),
            .masked   (mask[n]),
            .enabled  (ctrl.ch_en[n]),
            .idle_lvl (oinit[n]),
            .out      (pwm_out[n])
        );
    end

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
    import pwm_timer_pkg::*;
(
    input logic                         clk,
    input logic                         rst,
    input ctrl_t                        ctrl,
    input logic [CNT_W-1:0]             modulo,
    input logic [CNT_W-1:0]             start_val,
    input logic [NUM_CH-1:0]            pol,
    input logic [NUM_CH-1:0]            mask,
    input logic [NUM_CH-1:0][CNT_W-1:0] cmp,
    input logic                         cnt_load,
    input logic                         tick,
    input logic                         step,
    input logic [CNT_W-1:0]             cnt,
    input logic [NUM_CH-1:0]            pwm_out
);

    logic [CNT_W-1:0] cnt_inc;
    assign cnt_inc = cnt + CNT_W'(1);

    // R3
    src_off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.src == SRC_OFF && !cnt_load) |=> $stable(cnt));

    // R4
    step_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        step |-> tick);

    // R5
    wrap_to_start_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !cnt_load && cnt == modulo) |=> (cnt == $past(start_val)));

    // R5
    advance_by_one_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !cnt_load && cnt != modulo) |=> (cnt == $past(cnt_inc)));

    // R10
    reload_start_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_load |=> (cnt == $past(start_val)));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_duty
        // R6
        zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
            (cmp[n] == '0 && ctrl.ch_en[n] && !mask[n]) |-> (pwm_out[n] == pol[n]));
        // R6
        full_duty_chk: assert property (@(posedge clk) disable iff (rst)
            (cmp[n] > modulo && cnt <= modulo && ctrl.ch_en[n] && !mask[n])
            |-> (pwm_out[n] == !pol[n]));
    end

endmodule

bind pwm_shared_timer pwm_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .modulo    (modulo),
    .start_val (start_val),
    .pol       (pol),
    .mask      (mask),
    .cmp       (cmp),
    .cnt_load  (cnt_load),
    .tick      (tick),
    .step      (step),
    .cnt       (cnt),
    .pwm_out   (pwm_out)
);

// File: tb/pwm_shared_timer_test.sv
module pwm_shared_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fix_tick = 1'b0;
    logic        ext_tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [7:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;
    string cur_req = "R2";

    // behavioural model state
    int m_ctrl, m_mod, m_start, m_cnt, m_div, m_pol, m_oinit, m_mask;
    int m_cv [8];

    always #2 clk = ~clk;

    pwm_shared_timer uut (
        .clk       (clk),
        .rst       (rst),
        .fix_tick  (fix_tick),
        .ext_tick  (ext_tick),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    always @(negedge clk) begin
        fix_tick <= ($urandom % 3) == 0;
        ext_tick <= ($urandom % 5) == 0;
    end

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 0; m_mod = 0; m_start = 0; m_cnt = 0; m_div = 0;
            m_pol = 0; m_oinit = 0; m_mask = 'hFF;
            for (int n = 0; n < 8; n++) m_cv[n] = 0;
        end else begin
            int src, lim;
            bit tk;
            src = (m_ctrl >> 3) & 3;
            lim = (1 << (m_ctrl & 7)) - 1;
            tk  = (src == 1) || (src == 2 && fix_tick) || (src == 3 && ext_tick);
            if (bus_we && bus_addr[7:2] == 3) begin
                m_cnt = m_start;
                m_div = 0;
            end else if (tk) begin
                if (m_div >= lim) begin
                    m_div = 0;
                    m_cnt = (m_cnt == m_mod) ? m_start : ((m_cnt + 1) & 'hFFFF);
                end else begin
                    m_div++;
                end
            end
            if (bus_we) begin
                case (bus_addr[7:2])
                    0: m_ctrl  = bus_wdata & 'h00FF001F;
                    1: m_mod   = bus_wdata & 'hFFFF;
                    2: m_start = bus_wdata & 'hFFFF;
                    4: m_pol   = bus_wdata & 'hFF;
                    5: m_oinit = bus_wdata & 'hFF;
                    6: m_mask  = bus_wdata & 'hFF;
                    default: if (bus_addr[7:2] >= 8 && bus_addr[7:2] < 16)
                        m_cv[bus_addr[7:2] - 8] = bus_wdata & 'hFFFF;
                endcase
            end
        end
    end

    function automatic logic [7:0] exp_out();
        logic [7:0] e;
        for (int n = 0; n < 8; n++) begin
            if (((m_ctrl >> (16 + n)) & 1) == 0 || ((m_mask >> n) & 1) == 1)
                e[n] = ((m_oinit >> n) & 1) != 0;
            else
                e[n] = (m_cnt < m_cv[n]) ^ (((m_pol >> n) & 1) != 0);
        end
        return e;
    endfunction

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            checks++;
            if (pwm_out !== exp_out()) begin
                errors++;
                $display("FAIL %s: pwm_out actual %h expected %h (cnt model %0d)",
                         cur_req, pwm_out, exp_out(), m_cnt);
            end
        end
    end

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = addr[7:0]; bus_wdata = data;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input int addr, input int expv, input string req);
        @(negedge clk);
        bus_addr = addr[7:0];
        #1;
        checks++;
        if (bus_rdata !== expv[31:0]) begin
            errors++;
            $display("FAIL %s: read %h actual %h expected %h", req, addr, bus_rdata, expv);
        end
    endtask

    task automatic rd_cnt_chk(input string req);
        @(negedge clk);
        bus_addr = 8'h0C;
        #1;
        checks++;
        if (bus_rdata !== m_cnt) begin
            errors++;
            $display("FAIL %s: counter actual %0d expected %0d", req, bus_rdata, m_cnt);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int cvs [8];
        int hold;
        cvs = '{0, 3, 10, 5, 9, 1, 20, 7};
        repeat (4) @(negedge clk);
        rst = 1'b0;
        cmp_on = 1'b1;

        // R2: reset state
        cur_req = "R2";
        rd_chk('h18, 'hFF, "R2");
        rd_chk('h00, 0, "R2");
        rd_chk('h04, 0, "R2");
        rd_chk('h08, 0, "R2");
        rd_chk('h14, 0, "R2");
        rd_chk('h20, 0, "R2");
        rd_cnt_chk("R2");
        checks++;
        if (pwm_out !== 8'h00) begin
            errors++;
            $display("FAIL R2: pwm_out actual %h expected 00", pwm_out);
        end

        // R1: readback and unused bits
        cur_req = "R1";
        wr('h00, 'hFFFF_FFFF);
        rd_chk('h00, 'h00FF_001F, "R1");
        wr('h00, 0);
        wr('h04, 'hABCD_0009);
        rd_chk('h04, 9, "R1");
        wr('h10, 'h1234_56A5);
        rd_chk('h10, 'hA5, "R1");
        wr('h10, 0);
        for (int n = 0; n < 8; n++) wr('h20 + 4 * n, cvs[n]);
        rd_chk('h2C, 5, "R1");
        rd_chk('h3C, 7, "R1");
        rd_chk('h1C, 0, "R1");

        // R6: basic waveforms, all enabled, unmasked, system source
        cur_req = "R6";
        wr('h18, 0);
        wr('h00, 'h00FF_0008);
        run(40);
        rd_cnt_chk("R1");

        // R7: polarity
        cur_req = "R7";
        wr('h10, 'hA5);
        run(30);

        // R8: mask and fallback level
        cur_req = "R8";
        wr('h14, 'h3C);
        wr('h18, 'h0F);
        run(30);
        wr('h18, 0);
        wr('h10, 0);

        // R9: enable bits
        cur_req = "R9";
        wr('h00, 'h0055_0008);
        run(30);

        // R4: prescaler
        cur_req = "R4";
        wr('h00, 'h00FF_000A);
        run(100);
        rd_cnt_chk("R4");
        wr('h04, 2);
        wr('h00, 'h00FF_000F);
        run(1300);
        rd_cnt_chk("R4");
        wr('h04, 9);

        // R3: counting sources
        cur_req = "R3";
        wr('h00, 'h00FF_0010);
        run(150);
        rd_cnt_chk("R3");
        wr('h00, 'h00FF_0018);
        run(150);
        rd_cnt_chk("R3");
        wr('h00, 'h00FF_0000);
        @(negedge clk);
        bus_addr = 8'h0C;
        #1 hold = bus_rdata;
        run(20);
        rd_chk('h0C, hold, "R3");

        // R5: wrap to start value
        cur_req = "R5";
        wr('h08, 4);
        wr('h04, 12);
        wr('h0C, 0);
        rd_chk('h0C, 4, "R5");
        wr('h00, 'h00FF_0008);
        run(60);
        rd_cnt_chk("R5");

        // R10: reload mid prescale phase
        cur_req = "R10";
        wr('h00, 'h00FF_000B);
        run(13);
        wr('h0C, 'h77);
        rd_chk('h0C, 4, "R10");
        run(50);
        rd_cnt_chk("R10");

        done = 1'b1;
        finish_run();
    end

endmodule